// File: doc/BRIEF.md
# Cascadable 4-bit Register and Arithmetic Slice

This block is one 4-bit lane of a processor datapath. Four identical copies placed side by side form a 16-bit unit. Each copy keeps its own nibble of four accumulators, of the program counter and of a status word. It also holds its nibble of a 16-entry last-in-first-out stack. An arithmetic/logic unit with a ripple carry sits between the register file and the stack. A controller drives the same microcontrol fields into all four copies in every cycle. These fields choose the operand sources, the operation, the destination and the stack action. The copies talk to each other only through a carry chain and a zero chain.

The lowest slice takes its carry-in from the controller, and every higher slice takes the carry-out of the slice below it. The zero chain runs the same way. A slice reports "zero" only when its own result nibble is zero and the slice below also reported zero, so the top slice's zero output stands for the whole word. One slice is strapped as the most significant. It alone computes signed overflow, and it alone can capture overflow and carry into the status word. Incrementing the program counter is an ordinary increment operation on that register, so its carry ripples through the same chain. Adding a signed immediate to an accumulator while watching the top zero output supports a skip-on-zero loop counter.

Top module: `bitslice_dp`

## Requirements
- R1: After reset all four accumulators, the program counter and the status nibble read as 0. The stack is empty, and a pop of it returns 0.
- R2: Operation codes 0 (add, A+B+cin), 1 (subtract, A+~B+cin, with the controller supplying cin=1 at the low slice) and 6 (increment, A+cin) give the correct 16-bit sum across four chained slices. The top slice's carry-out is the carry of the word.
- R3: Operation codes 2 (AND), 3 (OR), 4 (XOR) and 5 (pass A) give the bitwise result and drive carry-out to 0 whatever the carry-in.
- R4: zout is 1 only when zin is 1 and the slice's result nibble is 0. With the low slice's zin tied to 1, the top zout flags a zero 16-bit result. Adding the immediate -1 to an accumulator flags zero exactly when the count reaches 0.
- R5: On the slice with msb_slice=1, ovf_o is set when an arithmetic result overflows in two's complement. On every other slice ovf_o stays 0.
- R6: Increment with source and destination both the program counter (source code 4, destination code 4) and cin=1 at the low slice adds one to the 16-bit counter. The carry passes between slices, so 0x0FFF becomes 0x1000 and 0xFFFF becomes 0x0000 with carry out.
- R7: A destination register is loaded from the result at the rising clock edge only while uc_wr is 1. Destination codes are 0-3 for the accumulators, 4 for the program counter and 5 for the status nibble. With uc_wr at 0 the register keeps its value.
- R8: uc_push stores the result on the stack, and a pop yields the values in reverse order of pushing. Source code 6 reads the stack top.
- R9: A push onto a full 16-entry stack overwrites the oldest entry. The following 16 pops return the 16 newest values.
- R10: A pop of an empty stack returns the value the last pop read and leaves the stack empty.
- R11: uc_push and uc_pop together on a non-empty stack replace the top entry with the result and leave the depth unchanged. On an empty stack the pair acts as a push.
- R12: With uc_flag_upd=1, the most significant slice loads its status bit 2 with overflow and bit 1 with carry of that cycle. In the 16-bit status word these are bit 14 (overflow) and bit 13 (carry). Other slices and the other bits are unchanged, and an explicit write to the status nibble takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| uc_op | input | 3 | Operation: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5 pass, 6 inc, 7 pass |
| uc_a_sel | input | 3 | Operand A: 0-3 accumulator, 4 PC, 5 status, 6 stack top, 7 data_i |
| uc_b_sel | input | 2 | Operand B accumulator number |
| uc_use_imm | input | 1 | Take operand B from imm_i instead |
| uc_dst | input | 3 | Destination: 0-3 accumulator, 4 PC, 5 status, 6-7 none |
| uc_wr | input | 1 | Write the result into the destination |
| uc_push | input | 1 | Push the result onto the stack |
| uc_pop | input | 1 | Pop the stack |
| uc_flag_upd | input | 1 | Capture overflow and carry into the status nibble (top slice only) |
| msb_slice | input | 1 | Strap: 1 on the most significant slice |
| imm_i | input | 4 | Immediate nibble |
| data_i | input | 4 | Data bus nibble from memory |
| data_o | output | 4 | Result nibble, toward memory |
| cin | input | 1 | Carry in from the slice below or the controller |
| cout | output | 1 | Carry out to the slice above |
| zin | input | 1 | Zero chain in (1 on the low slice) |
| zout | output | 1 | Zero chain out |
| ovf_o | output | 1 | Signed overflow, meaningful on the top slice |

## Verification
The stack's push and pop can fall in the same cycle, and the bench provokes this with both strobes raised on a stack that holds two entries. It judges the outcome only at the ports, by popping afterwards. The replaced value must come out first, then the untouched lower entry, and then an empty-stack pop must repeat that lower entry. This shows the depth did not change. The same pattern at zero depth, produced by the empty pops, must behave like a plain push.

// File: rtl/bsdp_pkg.sv
`timescale 1ns/1ps
package bsdp_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_PASS = 3'd5,
    OP_INC  = 3'd6,
    OP_RSV  = 3'd7
  } alu_op_e;

  // operand A source codes (0..3 are accumulators)
  localparam logic [2:0] SRC_PC  = 3'd4;
  localparam logic [2:0] SRC_FLG = 3'd5;
  localparam logic [2:0] SRC_STK = 3'd6;
  localparam logic [2:0] SRC_BUS = 3'd7;

  // destination codes (0..3 are accumulators, 6..7 write nothing)
  localparam logic [2:0] DST_PC  = 3'd4;
  localparam logic [2:0] DST_FLG = 3'd5;

endpackage

// File: rtl/bsdp_alu.sv
`timescale 1ns/1ps
module bsdp_alu
  import bsdp_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] y,
  output logic         cout,
  output logic         ctop
);

  logic [W-1:0] bb;
  logic [W-1:0] sum;
  logic [W:0]   c;
  logic         arith;

  always_comb begin
    case (alu_op_e'(op))
      OP_SUB:  bb = ~b;
      OP_INC:  bb = '0;
      default: bb = b;
    endcase
  end

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_rip
    assign sum[i]  = a[i] ^ bb[i] ^ c[i];
    assign c[i+1]  = (a[i] & bb[i]) | (c[i] & (a[i] ^ bb[i]));
  end

  always_comb begin
    case (alu_op_e'(op))
      OP_ADD, OP_SUB, OP_INC: y = sum;
      OP_AND:                 y = a & b;
      OP_OR:                  y = a | b;
      OP_XOR:                 y = a ^ b;
      default:                y = a;
    endcase
  end

  assign arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  assign cout  = arith & c[W];
  assign ctop  = arith & c[W-1];

endmodule

// File: rtl/bsdp_regs.sv
`timescale 1ns/1ps
module bsdp_regs
  import bsdp_pkg::*;
#(
  parameter  int W    = 4,
  parameter  int NACC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              dst,
  input  logic [W-1:0]            wd,
  input  logic                    flag_upd,
  input  logic                    ovf_in,
  input  logic                    cy_in,
  output logic [NACC-1:0][W-1:0]  acc,
  output logic [W-1:0]            pc,
  output logic [W-1:0]            flg
);

  localparam int FLG_OV = W - 2;
  localparam int FLG_CY = W - 3;

  logic [NACC-1:0][W-1:0] acc_d;
  logic [W-1:0]           pc_d;
  logic [W-1:0]           flg_d;
  logic                   flg_wr;

  assign flg_wr = wr_en && (dst == DST_FLG);

  always_comb begin
    acc_d = acc;
    pc_d  = pc;
    flg_d = flg;
    if (wr_en) begin
      for (int i = 0; i < NACC; i++) begin
        if (dst == 3'(i)) acc_d[i] = wd;
      end
      if (dst == DST_PC) pc_d = wd;
      if (flg_wr)        flg_d = wd;
    end
    if (flag_upd && !flg_wr) begin
      flg_d[FLG_OV] = ovf_in;
      flg_d[FLG_CY] = cy_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      pc  <= '0;
      flg <= '0;
    end else begin
      acc <= acc_d;
      pc  <= pc_d;
      flg <= flg_d;
    end
  end

  // R7: program counter holds unless it is the written destination
  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dst == DST_PC) |=> $stable(pc));

  // R12: captured overflow lands in its status bit
  assert_flag_ov_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && !flg_wr) |=> (flg[FLG_OV] == $past(ovf_in)
                               && flg[FLG_CY] == $past(cy_in)));

endmodule

// File: rtl/bsdp_lifo.sv
`timescale 1ns/1ps
module bsdp_lifo #(
  parameter  int W     = 4,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, tp, waddr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  last_q, last_d, mem_top;
  logic          we, nonempty;

  assign tp       = wp_q - AW'(1);
  assign nonempty = (cnt_q != '0);
  assign mem_top  = mem[tp];
  assign top      = nonempty ? mem_top : last_q;

  always_comb begin
    wp_d   = wp_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    we     = 1'b0;
    waddr  = wp_q;
    if (push && pop && nonempty) begin
      we     = 1'b1;
      waddr  = tp;
      last_d = mem_top;
    end else if (push) begin
      we   = 1'b1;
      wp_d = wp_q + AW'(1);
      if (cnt_q != FULL) cnt_d = cnt_q + CW'(1);
    end else if (pop && nonempty) begin
      wp_d   = tp;
      cnt_d  = cnt_q - CW'(1);
      last_d = mem_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      wp_q   <= wp_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // R8: a plain push below full deepens the stack by one
  assert_push_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q != FULL) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  // R9: a push on a full stack keeps it full
  assert_full_wraps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q == FULL) |=> (cnt_q == FULL));

  // R10: popping an empty stack changes nothing
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !nonempty) |=> (cnt_q == '0 && $stable(wp_q) && $stable(last_q)));

  // R11: push with pop on a non-empty stack keeps the depth
  assert_replace_depth_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && nonempty) |=> ($stable(cnt_q) && $stable(wp_q)));

endmodule

// File: rtl/bitslice_dp.sv
`timescale 1ns/1ps
module bitslice_dp
  import bsdp_pkg::*;
#(
  parameter  int W     = 4,
  parameter  int NACC  = 4,
  parameter  int DEPTH = 16,
  localparam int AIW   = $clog2(NACC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     uc_op,
  input  logic [2:0]     uc_a_sel,
  input  logic [AIW-1:0] uc_b_sel,
  input  logic           uc_use_imm,
  input  logic [2:0]     uc_dst,
  input  logic           uc_wr,
  input  logic           uc_push,
  input  logic           uc_pop,
  input  logic           uc_flag_upd,
  input  logic           msb_slice,
  input  logic [W-1:0]   imm_i,
  input  logic [W-1:0]   data_i,
  output logic [W-1:0]   data_o,
  input  logic           cin,
  output logic           cout,
  input  logic           zin,
  output logic           zout,
  output logic           ovf_o
);

  logic [1:0]             rs_q;
  logic                   rst_int_n;
  logic [NACC-1:0][W-1:0] acc;
  logic [W-1:0]           pc, flg, stk_top;
  logic [W-1:0]           opa, opb, res;
  logic                   ctop;

  // asynchronous assertion, release synchronised to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    case (uc_a_sel)
      SRC_PC:  opa = pc;
      SRC_FLG: opa = flg;
      SRC_STK: opa = stk_top;
      SRC_BUS: opa = data_i;
      default: opa = acc[uc_a_sel[AIW-1:0]];
    endcase
  end

  assign opb = uc_use_imm ? imm_i : acc[uc_b_sel];

  bsdp_alu #(.W(W)) u_alu (
    .op   (uc_op),
    .a    (opa),
    .b    (opb),
    .cin  (cin),
    .y    (res),
    .cout (cout),
    .ctop (ctop)
  );

  bsdp_regs #(.W(W), .NACC(NACC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (uc_wr),
    .dst      (uc_dst),
    .wd       (res),
    .flag_upd (uc_flag_upd & msb_slice),
    .ovf_in   (ovf_o),
    .cy_in    (cout),
    .acc      (acc),
    .pc       (pc),
    .flg      (flg)
  );

  bsdp_lifo #(.W(W), .DEPTH(DEPTH)) u_lifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (uc_push),
    .pop   (uc_pop),
    .wdata (res),
    .top   (stk_top)
  );

  assign data_o = res;
  assign zout   = zin & (res == '0);
  assign ovf_o  = msb_slice & (ctop ^ cout);

  // R3: logic and pass operations never produce a carry
  assert_logic_nocarry_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (uc_op == OP_AND || uc_op == OP_OR || uc_op == OP_XOR || uc_op == OP_PASS) |-> !cout);

  // R4: a raised zero output implies a clear result nibble and a raised chain input
  assert_zero_chain_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    zout |-> (data_o == '0 && zin));

  // R5: same-sign addition whose sign flips must flag overflow on the top slice
  assert_add_ovf_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (msb_slice && uc_op == OP_ADD && opa[W-1] == opb[W-1] && res[W-1] != opa[W-1]) |-> ovf_o);

endmodule

// File: tb/bitslice_dp_bench.sv
`timescale 1ns/1ps
module bitslice_dp_bench;
  import bsdp_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  op, a_sel, dst;
  logic [1:0]  b_sel;
  logic        use_imm, wr, push, pop, fupd;
  logic [15:0] imm16, din16;
  logic        cin0, zin0;
  wire  [15:0] dout16;
  wire  [4:0]  carry;
  wire  [4:0]  zch;
  wire  [3:0]  ovf;

  assign carry[0] = cin0;
  assign zch[0]   = zin0;

  for (genvar s = 0; s < 4; s++) begin : g_sl
    bitslice_dp u_bitslice_dp (
      .clk(clk), .rst_n(rst_n),
      .uc_op(op), .uc_a_sel(a_sel), .uc_b_sel(b_sel), .uc_use_imm(use_imm),
      .uc_dst(dst), .uc_wr(wr), .uc_push(push), .uc_pop(pop),
      .uc_flag_upd(fupd), .msb_slice(s == 3),
      .imm_i(imm16[4*s +: 4]), .data_i(din16[4*s +: 4]), .data_o(dout16[4*s +: 4]),
      .cin(carry[s]), .cout(carry[s+1]), .zin(zch[s]), .zout(zch[s+1]),
      .ovf_o(ovf[s])
    );
  end

  int          errors = 0;
  int          checks = 0;
  logic [15:0] r_res;
  logic        r_c, r_z, r_v, r_vlow;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] o, input logic [2:0] as, input logic [1:0] bs,
                     input logic ui, input logic [2:0] d, input logic w,
                     input logic pu, input logic po, input logic fu,
                     input logic [15:0] im, input logic [15:0] dn, input logic ci);
    @(negedge clk);
    op = o; a_sel = as; b_sel = bs; use_imm = ui; dst = d; wr = w;
    push = pu; pop = po; fupd = fu; imm16 = im; din16 = dn; cin0 = ci;
    #1;
    r_res = dout16; r_c = carry[4]; r_z = zch[4]; r_v = ovf[3]; r_vlow = |ovf[2:0];
  endtask

  task automatic ld(input logic [2:0] d, input logic [15:0] v);
    cyc(OP_PASS, SRC_BUS, 2'd0, 1'b0, d, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, v, 1'b0);
  endtask

  task automatic rd(input logic [2:0] s);
    cyc(OP_PASS, s, 2'd0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b0);
  endtask

  task automatic spush(input logic [15:0] v);
    cyc(OP_PASS, SRC_BUS, 2'd0, 1'b0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, v, 1'b0);
  endtask

  task automatic spop();
    cyc(OP_PASS, SRC_STK, 2'd0, 1'b0, 3'd7, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 1'b0);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // {op, a, b, cin, result, carry, zero, overflow}
  localparam int NV = 12;
  localparam logic [54:0] VEC [NV] = '{
    {3'd0, 16'h1234, 16'h1111, 1'b0, 16'h2345, 1'b0, 1'b0, 1'b0},
    {3'd0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {3'd0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b0, 1'b1},
    {3'd1, 16'h5000, 16'h1000, 1'b1, 16'h4000, 1'b1, 1'b0, 1'b0},
    {3'd1, 16'h1000, 16'h2000, 1'b1, 16'hF000, 1'b0, 1'b0, 1'b0},
    {3'd1, 16'h8000, 16'h0001, 1'b1, 16'h7FFF, 1'b1, 1'b0, 1'b1},
    {3'd2, 16'hF0F0, 16'h3C3C, 1'b1, 16'h3030, 1'b0, 1'b0, 1'b0},
    {3'd3, 16'h0F00, 16'h00F0, 1'b1, 16'h0FF0, 1'b0, 1'b0, 1'b0},
    {3'd4, 16'hAAAA, 16'hAAAA, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0},
    {3'd5, 16'h1357, 16'hFFFF, 1'b1, 16'h1357, 1'b0, 1'b0, 1'b0},
    {3'd6, 16'hFFFF, 16'h1234, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},
    {3'd6, 16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_up();
  end

  initial begin
    op = OP_PASS; a_sel = 3'd0; b_sel = 2'd0; use_imm = 1'b0; dst = 3'd7; wr = 1'b0;
    push = 1'b0; pop = 1'b0; fupd = 1'b0; imm16 = '0; din16 = '0; cin0 = 1'b0; zin0 = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int k = 0; k < 6; k++) begin
      rd(3'(k));
      chk("R1 register after reset", r_res, 16'h0);
    end
    spop();
    chk("R1 empty stack after reset", r_res, 16'h0);

    // R2 R3 R4 R5: vector table
    for (int k = 0; k < NV; k++) begin
      logic [54:0] v;
      string tag;
      v = VEC[k];
      tag = (v[54:52] <= 3'd1 || v[54:52] == 3'd6) ? "R2 arithmetic" : "R3 logic";
      ld(3'd0, v[51:36]);
      ld(3'd1, v[35:20]);
      cyc(v[54:52], 3'd0, 2'd1, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, v[19]);
      chk(tag, r_res, v[18:3]);
      chk({tag, " carry"}, {15'h0, r_c}, {15'h0, v[2]});
      chk("R4 zero chain", {15'h0, r_z}, {15'h0, v[1]});
      chk("R5 overflow top", {15'h0, r_v}, {15'h0, v[0]});
      chk("R5 overflow low slices", {15'h0, r_vlow}, 16'h0);
    end

    // R4: broken zero chain and count-down to zero
    ld(3'd0, 16'h0000);
    zin0 = 1'b0;
    rd(3'd0);
    chk("R4 zin low masks zero", {15'h0, r_z}, 16'h0);
    zin0 = 1'b1;
    rd(3'd0);
    chk("R4 zin high passes zero", {15'h0, r_z}, 16'h1);
    ld(3'd1, 16'h0003);
    for (int k = 2; k >= 0; k--) begin
      cyc(OP_ADD, 3'd1, 2'd0, 1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0, 1'b0);
      chk("R4 add -1 result", r_res, 16'(k));
      chk("R4 add -1 zero flag", {15'h0, r_z}, (k == 0) ? 16'h1 : 16'h0);
    end

    // R6: program counter increment
    ld(DST_PC, 16'h0FFF);
    cyc(OP_INC, SRC_PC, 2'd0, 1'b0, DST_PC, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1);
    rd(SRC_PC);
    chk("R6 pc 0FFF+1", r_res, 16'h1000);
    ld(DST_PC, 16'hFFFF);
    cyc(OP_INC, SRC_PC, 2'd0, 1'b0, DST_PC, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 1'b1);
    chk("R6 pc wrap carry", {15'h0, r_c}, 16'h1);
    rd(SRC_PC);
    chk("R6 pc FFFF+1", r_res, 16'h0000);

    // R7: write enable
    ld(3'd2, 16'h00AA);
    cyc(OP_ADD, 3'd2, 2'd0, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0, 1'b0);
    chk("R7 result without write", r_res, 16'h00AB);
    rd(3'd2);
    chk("R7 no write keeps value", r_res, 16'h00AA);
    cyc(OP_ADD, 3'd2, 2'd0, 1'b1, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0, 1'b0);
    rd(3'd2);
    chk("R7 write lands", r_res, 16'h00AB);

    // R8: order
    for (int k = 0; k < 5; k++) spush(16'hA000 + 16'(k));
    for (int k = 4; k >= 0; k--) begin
      spop();
      chk("R8 lifo order", r_res, 16'hA000 + 16'(k));
    end

    // R9: overflow of a full stack
    for (int k = 0; k < 17; k++) spush(16'h0100 + 16'(k));
    for (int k = 16; k >= 1; k--) begin
      spop();
      chk("R9 newest sixteen", r_res, 16'h0100 + 16'(k));
    end

    // R10: empty pops
    spop();
    chk("R10 empty pop repeats last", r_res, 16'h0101);
    spop();
    chk("R10 second empty pop", r_res, 16'h0101);
    spush(16'hBEEF);
    spop();
    chk("R10 push after empty", r_res, 16'hBEEF);
    spop();
    chk("R10 empty again", r_res, 16'hBEEF);

    // R11: simultaneous push and pop
    spush(16'h1111);
    spush(16'h2222);
    cyc(OP_PASS, SRC_BUS, 2'd0, 1'b0, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, 16'h3333, 1'b0);
    spop();
    chk("R11 replaced top", r_res, 16'h3333);
    spop();
    chk("R11 lower entry kept", r_res, 16'h1111);
    spop();
    chk("R11 depth unchanged", r_res, 16'h1111);
    cyc(OP_PASS, SRC_BUS, 2'd0, 1'b0, 3'd7, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0, 16'h4444, 1'b0);
    spop();
    chk("R11 empty pair pushes", r_res, 16'h4444);

    // R12: status capture
    ld(DST_FLG, 16'h0000);
    ld(3'd0, 16'h7FFF);
    ld(3'd1, 16'h0001);
    cyc(OP_ADD, 3'd0, 2'd1, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0);
    rd(SRC_FLG);
    chk("R12 overflow to bit 14", r_res, 16'h4000);
    ld(3'd0, 16'hFFFF);
    cyc(OP_ADD, 3'd0, 2'd1, 1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0);
    rd(SRC_FLG);
    chk("R12 carry to bit 13", r_res, 16'h2000);
    cyc(OP_ADD, 3'd0, 2'd1, 1'b0, DST_FLG, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 16'h0, 1'b0);
    rd(SRC_FLG);
    chk("R12 explicit write wins", r_res, 16'h0000);

    finish_up();
  end

endmodule